// File: doc/BRIEF.md
# Partitionable Fixed-Point Lane ALU

This block is the arithmetic core of one 64-bit vector lane. The lane can be treated as four 16-bit elements, two 32-bit elements or one 64-bit element, and every element is processed on its own. No carry, borrow or shifted bit crosses from one element into the next. The operations are all signed fixed-point: wrapping and saturating add and subtract, a right shift that rounds, a left shift that saturates, multiplies that return the low half, the high half, or a rounded and shifted form of the full product, and a narrowing clamp to half the element width.

Each operation carries a per-element write mask. An element whose mask bit is clear takes its value from the previous destination contents, which come in on a separate input. The outputs are registered. An accepted operation produces its result and one saturation flag per element at the next clock edge. All element products come from one array of 16x16 multiplier blocks whose partial products are summed for the wider elements.

Top module: `lane_fxp_alu`

## Requirements
- R1: While reset is asserted, and until the first operation has been accepted after it, `out_valid`, `result` and `sat_flags` are all zero.
- R2: An operation presented with `in_valid` high appears on `result`/`sat_flags` with `out_valid` high one clock later. A cycle with `in_valid` low drops `out_valid` and leaves `result` and `sat_flags` unchanged.
- R3: `esize` 0, 1 and 2 select 16-, 32- and 64-bit elements, and 3 behaves as 2. Element i occupies bits [i*EW +: EW], and no carry or shifted bit crosses an element boundary. The shift count is `shamt` modulo EW.
- R4: Opcode 0 adds and opcode 2 subtracts (a minus b), both wrapping with no flag. Opcodes 1 and 3 do the same but clamp to the signed EW-bit maximum or minimum and set the element flag when they clamp.
- R5: Opcode 4 adds 2^(s-1) to the element and then shifts it arithmetically right by s. When s is 0 the element is unchanged.
- R6: Opcode 5 shifts left by s. If the signed value cannot be represented, the result clamps to the maximum (for non-negative a) or the minimum (for negative a), and the flag is set.
- R7: Opcode 6 returns the low EW bits and opcode 7 the high EW bits of the 2*EW-bit signed product a*b. Neither sets a flag.
- R8: Opcode 8 forms the full signed product, adds 2^(s-1) (nothing when s is 0), shifts it arithmetically right by s, and saturates to EW bits with a flag.
- R9: Opcode 9 clamps a to the signed EW/2-bit range and returns it sign-extended to EW bits. The flag is set when it clamps.
- R10: `mask[i]` enables element i. A masked-off element takes bits [i*EW +: EW] of `dest_old` and its flag is 0. Flag bits at indices beyond the element count are 0.
- R11: Opcodes 10 to 15 pass `src_a` through, subject to the mask, with no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode |
| esize | input | 2 | Element width select |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| dest_old | input | 64 | Previous destination value, kept in masked-off elements |
| shamt | input | 6 | Shift amount, taken modulo the element width |
| mask | input | 4 | Per-element write enable |
| out_valid | output | 1 | Result registers loaded last cycle |
| result | output | 64 | Element results |
| sat_flags | output | 4 | Per-element saturation flags |

## Verification
Every result and flag is due exactly one rising edge after the edge that samples `in_valid`. The bench drives each operation on a falling edge, drops `in_valid` on the next falling edge, and compares outputs at that moment, which lies half a period after the capturing edge. An idle cycle that follows with changed operands confirms that the registered values hold. Expected values come from a reference model that works on sign-extended wide integers rather than on partial products.

// File: rtl/lane_fxp_pkg.sv
package lane_fxp_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADDS   = 4'd1,
    OP_SUB    = 4'd2,
    OP_SUBS   = 4'd3,
    OP_SRAR   = 4'd4,
    OP_SLLS   = 4'd5,
    OP_MULLO  = 4'd6,
    OP_MULHI  = 4'd7,
    OP_MULRS  = 4'd8,
    OP_NARROW = 4'd9
  } lane_op_e;

endpackage

// File: rtl/lane_fxp_mul.sv
// Element products for every width level, assembled from 16x16 unsigned blocks.
module lane_fxp_mul #(
  parameter int LANE_W = 64,
  parameter int BLK_W  = 16,
  parameter int NLEV   = 3
) (
  input  logic [LANE_W-1:0]                 a,
  input  logic [LANE_W-1:0]                 b,
  output logic [NLEV-1:0][2*LANE_W-1:0]     prod
);
  localparam int NSLOT = LANE_W / BLK_W;
  localparam int PPW   = 2 * BLK_W;

  logic [PPW-1:0] pp [NSLOT][NSLOT];

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_row
    for (genvar gj = 0; gj < NSLOT; gj++) begin : g_col
      assign pp[gi][gj] = PPW'(a[gi*BLK_W +: BLK_W]) * PPW'(b[gj*BLK_W +: BLK_W]);
    end
  end

  for (genvar lv = 0; lv < NLEV; lv++) begin : g_lev
    localparam int EW  = BLK_W << lv;
    localparam int NE  = LANE_W / EW;
    localparam int SPE = EW / BLK_W;
    localparam int PW  = 2 * EW;
    for (genvar e = 0; e < NE; e++) begin : g_elem
      logic [EW-1:0] ea, eb;
      logic [PW-1:0] acc;
      assign ea = a[e*EW +: EW];
      assign eb = b[e*EW +: EW];
      always_comb begin
        acc = '0;
        for (int i = 0; i < SPE; i++) begin
          for (int j = 0; j < SPE; j++) begin
            acc = acc + (PW'(pp[e*SPE+i][e*SPE+j]) << (BLK_W*(i+j)));
          end
        end
        // signed correction of the unsigned product, modulo 2^PW
        if (ea[EW-1]) acc = acc - {eb, {EW{1'b0}}};
        if (eb[EW-1]) acc = acc - {ea, {EW{1'b0}}};
      end
      assign prod[lv][e*PW +: PW] = acc;
    end
  end
endmodule

// File: rtl/lane_fxp_elem.sv
// One element of width EW: all fixed-point operations and clamping.
module lane_fxp_elem #(
  parameter int EW      = 16,
  parameter int SHAMT_W = 6
) (
  input  lane_fxp_pkg::lane_op_e op,
  input  logic [SHAMT_W-1:0]     shamt,
  input  logic [EW-1:0]          a,
  input  logic [EW-1:0]          b,
  input  logic [2*EW-1:0]        prod,
  output logic [EW-1:0]          res,
  output logic                   sat
);
  import lane_fxp_pkg::*;

  localparam int SHW = $clog2(EW);
  localparam int HW  = EW / 2;
  localparam int PW  = 2 * EW;
  localparam logic [EW-1:0] SMAX = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] SMIN = {1'b1, {(EW-1){1'b0}}};
  localparam logic [EW-1:0] NMAX = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic [EW-1:0] NMIN = {{(HW+1){1'b1}}, {(HW-1){1'b0}}};

  logic [SHW-1:0]       sh;
  logic signed [EW:0]   sum_w, dif_w, half_w, rnd_w, srar_w;
  logic [EW-1:0]        shl;
  logic signed [EW-1:0] back;
  logic signed [PW:0]   half_p, prnd, pshift;
  logic                 fit_sum, fit_dif, fit_shl, fit_mul, fit_nar;

  assign sh = shamt[SHW-1:0];

  always_comb begin
    sum_w   = $signed({a[EW-1], a}) + $signed({b[EW-1], b});
    dif_w   = $signed({a[EW-1], a}) - $signed({b[EW-1], b});
    fit_sum = (sum_w[EW] == sum_w[EW-1]);
    fit_dif = (dif_w[EW] == dif_w[EW-1]);

    half_w  = $signed(((EW+1)'(1) << sh) >> 1);
    rnd_w   = $signed({a[EW-1], a}) + half_w;
    srar_w  = rnd_w >>> sh;

    shl     = a << sh;
    back    = $signed(shl) >>> sh;
    fit_shl = (back == $signed(a));

    half_p  = $signed(((PW+1)'(1) << sh) >> 1);
    prnd    = $signed({prod[PW-1], prod}) + half_p;
    pshift  = prnd >>> sh;
    fit_mul = (&pshift[PW:EW-1]) | ~(|pshift[PW:EW-1]);

    fit_nar = (&a[EW-1:HW-1]) | ~(|a[EW-1:HW-1]);
  end

  always_comb begin
    res = a;
    sat = 1'b0;
    case (op)
      OP_ADD:   res = sum_w[EW-1:0];
      OP_SUB:   res = dif_w[EW-1:0];
      OP_ADDS: begin
        sat = ~fit_sum;
        res = fit_sum ? sum_w[EW-1:0] : (sum_w[EW] ? SMIN : SMAX);
      end
      OP_SUBS: begin
        sat = ~fit_dif;
        res = fit_dif ? dif_w[EW-1:0] : (dif_w[EW] ? SMIN : SMAX);
      end
      OP_SRAR:  res = srar_w[EW-1:0];
      OP_SLLS: begin
        sat = ~fit_shl;
        res = fit_shl ? shl : (a[EW-1] ? SMIN : SMAX);
      end
      OP_MULLO: res = prod[EW-1:0];
      OP_MULHI: res = prod[PW-1:EW];
      OP_MULRS: begin
        sat = ~fit_mul;
        res = fit_mul ? pshift[EW-1:0] : (pshift[PW] ? SMIN : SMAX);
      end
      OP_NARROW: begin
        sat = ~fit_nar;
        res = fit_nar ? a : (a[EW-1] ? NMIN : NMAX);
      end
      default: begin
        res = a;
        sat = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lane_fxp_alu.sv
module lane_fxp_alu #(
  parameter int  LANE_W  = 64,
  parameter int  BLK_W   = 16,
  localparam int NSLOT   = LANE_W / BLK_W,
  localparam int SHAMT_W = $clog2(LANE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [3:0]         op,
  input  logic [1:0]         esize,
  input  logic [LANE_W-1:0]  src_a,
  input  logic [LANE_W-1:0]  src_b,
  input  logic [LANE_W-1:0]  dest_old,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [NSLOT-1:0]   mask,
  output logic               out_valid,
  output logic [LANE_W-1:0]  result,
  output logic [NSLOT-1:0]   sat_flags
);
  import lane_fxp_pkg::*;

  localparam int NLEV = $clog2(NSLOT) + 1;
  localparam int LVW  = $clog2(NLEV) > 0 ? $clog2(NLEV) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lane_op_e op_e;
  assign op_e = lane_op_e'(op);

  logic [NLEV-1:0][2*LANE_W-1:0] prod;
  logic [NLEV-1:0][LANE_W-1:0]   lvl_res;
  logic [NLEV-1:0][NSLOT-1:0]    lvl_flag;

  lane_fxp_mul #(
    .LANE_W (LANE_W),
    .BLK_W  (BLK_W),
    .NLEV   (NLEV)
  ) u_mul (
    .a    (src_a),
    .b    (src_b),
    .prod (prod)
  );

  for (genvar lv = 0; lv < NLEV; lv++) begin : g_lev
    localparam int EW = BLK_W << lv;
    localparam int NE = LANE_W / EW;
    for (genvar e = 0; e < NSLOT; e++) begin : g_elem
      if (e < NE) begin : g_act
        logic [EW-1:0] e_res;
        logic          e_sat;
        lane_fxp_elem #(
          .EW      (EW),
          .SHAMT_W (SHAMT_W)
        ) u_elem (
          .op    (op_e),
          .shamt (shamt),
          .a     (src_a[e*EW +: EW]),
          .b     (src_b[e*EW +: EW]),
          .prod  (prod[lv][e*2*EW +: 2*EW]),
          .res   (e_res),
          .sat   (e_sat)
        );
        assign lvl_res[lv][e*EW +: EW] = mask[e] ? e_res : dest_old[e*EW +: EW];
        assign lvl_flag[lv][e]         = mask[e] & e_sat;
      end else begin : g_idle
        assign lvl_flag[lv][e] = 1'b0;
      end
    end
  end

  logic [LVW-1:0] lv_sel;
  always_comb begin
    if (32'(esize) >= NLEV) lv_sel = LVW'(NLEV - 1);
    else                    lv_sel = LVW'(esize);
  end

  // next state
  logic              valid_d;
  logic [LANE_W-1:0] result_d;
  logic [NSLOT-1:0]  flags_d;
  logic              load_en;

  assign load_en = in_valid;

  always_comb begin
    valid_d  = in_valid;
    result_d = lvl_res[lv_sel];
    flags_d  = lvl_flag[lv_sel];
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      result    <= '0;
      sat_flags <= '0;
    end else if (load_en) begin
      result    <= result_d;
      sat_flags <= flags_d;
    end
  end
endmodule

// File: rtl/lane_fxp_alu_chk.sv
module lane_fxp_alu_chk #(
  parameter int LANE_W = 64,
  parameter int BLK_W  = 16
) (
  input logic                      clk,
  input logic                      rst_q_n,
  input logic                      in_valid,
  input logic [3:0]                op,
  input logic [1:0]                esize,
  input logic [LANE_W-1:0]         src_a,
  input logic [LANE_W-1:0]         dest_old,
  input logic [LANE_W/BLK_W-1:0]   mask,
  input logic                      out_valid,
  input logic [LANE_W-1:0]         result,
  input logic [LANE_W/BLK_W-1:0]   sat_flags
);
  localparam int NSLOT = LANE_W / BLK_W;

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(sat_flags))); // R2

  AST_WRAP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && (op == 4'd0 || op == 4'd2)) |=> (sat_flags == '0)); // R4

  AST_MUL_HALF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && (op == 4'd6 || op == 4'd7)) |=> (sat_flags == '0)); // R7

  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && esize == 2'd0 && !mask[0]) |=>
      (result[BLK_W-1:0] == $past(dest_old[BLK_W-1:0]) && !sat_flags[0])); // R10

  AST_WIDE_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && esize[1]) |=> (sat_flags[NSLOT-1:1] == '0)); // R10

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && op >= 4'd10 && mask == {NSLOT{1'b1}}) |=>
      (result == $past(src_a) && sat_flags == '0)); // R11
endmodule

bind lane_fxp_alu lane_fxp_alu_chk #(
  .LANE_W (LANE_W),
  .BLK_W  (BLK_W)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_int_n),
  .in_valid  (in_valid),
  .op        (op),
  .esize     (esize),
  .src_a     (src_a),
  .dest_old  (dest_old),
  .mask      (mask),
  .out_valid (out_valid),
  .result    (result),
  .sat_flags (sat_flags)
);

// File: tb/lane_fxp_alu_bench.sv
module lane_fxp_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [1:0]  esize;
  logic [63:0] src_a, src_b, dest_old;
  logic [5:0]  shamt;
  logic [3:0]  mask;
  logic        out_valid;
  logic [63:0] result;
  logic [3:0]  sat_flags;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lane_fxp_alu u_lane_fxp_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .esize     (esize),
    .src_a     (src_a),
    .src_b     (src_b),
    .dest_old  (dest_old),
    .shamt     (shamt),
    .mask      (mask),
    .out_valid (out_valid),
    .result    (result),
    .sat_flags (sat_flags)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd2, 4'd3: return "R4";
      4'd4:                   return "R5";
      4'd5:                   return "R6";
      4'd6, 4'd7:             return "R7";
      4'd8:                   return "R8";
      4'd9:                   return "R9";
      default:                return "R11";
    endcase
  endfunction

  // reference on sign-extended wide integers
  function automatic void ref_model(
    input  logic [3:0]  o, input logic [1:0] es,
    input  logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
    input  logic [5:0]  sa_in, input logic [3:0] m,
    output logic [63:0] r, output logic [3:0] f);
    int ew, n, sh, cw;
    logic [63:0] emask, ae, be, re;
    logic signed [129:0] sa, sb, v, mx, mn, hf;
    logic fl;
    ew = (es == 2'd0) ? 16 : (es == 2'd1) ? 32 : 64;
    n  = 64 / ew;
    sh = int'(sa_in) % ew;
    emask = (ew == 64) ? {64{1'b1}} : ((64'd1 << ew) - 64'd1);
    r = '0;
    f = '0;
    for (int e = 0; e < n; e++) begin
      ae = (a >> (e*ew)) & emask;
      be = (b >> (e*ew)) & emask;
      sa = 130'(ae);
      sa = (sa <<< (130 - ew)) >>> (130 - ew);
      sb = 130'(be);
      sb = (sb <<< (130 - ew)) >>> (130 - ew);
      hf = (sh == 0) ? 130'sd0 : (130'sd1 <<< (sh - 1));
      cw = (o == 4'd9) ? ew / 2 : ew;
      mx = (130'sd1 <<< (cw - 1)) - 130'sd1;
      mn = -(130'sd1 <<< (cw - 1));
      fl = 1'b0;
      case (o)
        4'd0, 4'd1: v = sa + sb;
        4'd2, 4'd3: v = sa - sb;
        4'd4:       v = (sa + hf) >>> sh;
        4'd5:       v = sa <<< sh;
        4'd6:       v = sa * sb;
        4'd7:       v = (sa * sb) >>> ew;
        4'd8:       v = (sa * sb + hf) >>> sh;
        4'd9:       v = sa;
        default:    v = sa;
      endcase
      if (o == 4'd1 || o == 4'd3 || o == 4'd5 || o == 4'd8 || o == 4'd9) begin
        if (v > mx) begin v = mx; fl = 1'b1; end
        else if (v < mn) begin v = mn; fl = 1'b1; end
      end
      re = v[63:0] & emask;
      if (m[e]) begin
        r    = r | (re << (e*ew));
        f[e] = fl;
      end else begin
        r = r | (((d >> (e*ew)) & emask) << (e*ew));
      end
    end
  endfunction

  task automatic run_op(input logic [3:0] o, input logic [1:0] es,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
                        input logic [5:0] s, input logic [3:0] m, input string tag);
    logic [63:0] er;
    logic [3:0]  ef;
    ref_model(o, es, a, b, d, s, m, er, ef);
    @(negedge clk);
    in_valid = 1'b1; op = o; esize = es; src_a = a; src_b = b;
    dest_old = d; shamt = s; mask = m;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " result"}, result, er);
    check({tag, " flags"}, {60'd0, sat_flags}, {60'd0, ef});
    check("R2 valid", {63'd0, out_valid}, 64'd1);
  endtask

  function automatic logic [63:0] pick_val();
    case ($urandom % 5)
      0: return {4{16'h7FFF}};
      1: return {4{16'h8000}};
      2: return {$urandom % 64'd300} - 64'd150;
      3: return {{32{1'b1}}, $urandom};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held_r;
    logic [3:0]  held_f;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op = '0; esize = '0;
    src_a = '0; src_b = '0; dest_old = '0; shamt = '0; mask = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 result after reset", result, 64'd0);
    check("R1 flags after reset", {60'd0, sat_flags}, 64'd0);

    // R4 wrap and clamp, 16-bit
    run_op(4'd0, 2'd0, 64'h0000_0000_0000_7FFF, 64'h1, 64'h0, 6'd0, 4'hF, "R4 add wrap");
    run_op(4'd1, 2'd0, 64'h0000_0000_0000_7FFF, 64'h1, 64'h0, 6'd0, 4'hF, "R4 adds clamp");
    run_op(4'd3, 2'd0, 64'h8000_8000_0000_8000, 64'h0001_FFFF_0001_0001, 64'h0, 6'd0, 4'hF, "R4 subs");
    // R3 no carry across boundary; esize 3 behaves as 64
    run_op(4'd0, 2'd0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 64'h0, 6'd0, 4'hF, "R3 boundary16");
    run_op(4'd0, 2'd1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0, 6'd0, 4'h3, "R3 boundary32");
    run_op(4'd1, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 6'd0, 4'h1, "R3 esize3");
    // R5 rounding right shift
    run_op(4'd4, 2'd0, 64'h0003_FFFD_7FFF_8000, 64'h0, 64'h0, 6'd1, 4'hF, "R5 srar s1");
    run_op(4'd4, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h0, 6'd16, 4'hF, "R5 srar s0");
    // R6 saturating left shift
    run_op(4'd5, 2'd0, 64'h4000_C000_0001_FFFF, 64'h0, 64'h0, 6'd2, 4'hF, "R6 slls");
    // R7 product halves, min*min
    run_op(4'd6, 2'd0, 64'h8000_8000_FFFF_1234, 64'h8000_7FFF_FFFF_0010, 64'h0, 6'd0, 4'hF, "R7 mullo");
    run_op(4'd7, 2'd1, 64'h8000_0000_8000_0000, 64'h8000_0000_7FFF_FFFF, 64'h0, 6'd0, 4'h3, "R7 mulhi");
    run_op(4'd7, 2'd2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 6'd0, 4'h1, "R7 mulhi64");
    // R8 rounded shifted product with clamp
    run_op(4'd8, 2'd0, 64'h8000_4000_0003_FFFF, 64'h8000_4000_0003_0001, 64'h0, 6'd15, 4'hF, "R8 mulrs");
    run_op(4'd8, 2'd2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 6'd63, 4'h1, "R8 mulrs64");
    // R9 narrowing
    run_op(4'd9, 2'd0, 64'h007F_0080_FF80_FF7F, 64'h0, 64'h0, 6'd0, 4'hF, "R9 narrow16");
    run_op(4'd9, 2'd2, 64'h0000_0001_0000_0000, 64'h0, 64'h0, 6'd0, 4'h1, "R9 narrow64");
    // R10 mask keeps old destination, no flag
    run_op(4'd1, 2'd0, {4{16'h7FFF}}, {4{16'h7FFF}}, 64'hAAAA_BBBB_CCCC_DDDD, 6'd0, 4'b0101, "R10 mask");
    run_op(4'd1, 2'd1, 64'h7FFF_FFFF_7FFF_FFFF, 64'h1_0000_0001, 64'h1111_2222_3333_4444, 6'd0, 4'b1110, "R10 mask32");
    // R11 undefined opcodes pass src_a
    run_op(4'd12, 2'd0, 64'hDEAD_BEEF_0123_4567, 64'h5, 64'h0, 6'd3, 4'hF, "R11 passthrough");

    // R2 hold while idle with changed inputs
    held_r = result;
    held_f = sat_flags;
    src_a = 64'h1; src_b = 64'h2; op = 4'd0; mask = 4'hF;
    @(negedge clk);
    check("R2 hold result", result, held_r);
    check("R2 hold flags", {60'd0, sat_flags}, {60'd0, held_f});
    check("R2 valid low", {63'd0, out_valid}, 64'd0);

    for (int k = 0; k < 400; k++) begin
      logic [3:0] o;
      o = 4'($urandom % 12);
      run_op(o, 2'($urandom % 4), pick_val(), pick_val(), {$urandom, $urandom},
             6'($urandom), 4'($urandom), req_of(o));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule